// File: doc/BRIEF.md
# Two-Channel Serial Word Receiver for a 12-Bit DAC Pair

This block is the digital front end of a pair of 12-bit voltage-output converters. A host shifts 16-bit words into it over a three-wire serial link: a serial clock, a data line, and an active-low frame strobe. Each word starts with a three-bit header that the block discards. A routing bit follows the header, and the last twelve bits are the payload. The routing bit decides which of two channels takes the payload.

Each channel holds the payload in a staging register. A second register, the output latch, holds the value the converter core sees. While the load strobe is held low, the latches copy the staging registers on the system clock. The latches therefore update together, so a host can stage both channels and then change both outputs at once. An asynchronous clear empties both latches.

A coding input sets how each latch maps to the code that goes to the core. In straight binary the value passes through unchanged. In two's complement the top bit is inverted. A cleared latch therefore produces code 0x000 in binary mode and mid-scale code 0x800 in two's-complement mode.

Top module: `dual_dac_serial_if`

## Requirements
- R1: A frame holds exactly 16 bits, sent most significant bit first. Each bit is taken on a falling edge of `sclk` while `sync_n` is low. The last 12 bits (bit positions 11..0 of the word) become the payload. The first three bits (positions 15..13) have no effect.
- R2: Word bit 12 selects the channel: 0 writes the payload to channel A's staging register and 1 writes it to channel B's. The other channel's staging register keeps its value.
- R3: Latches hold their value while `ldac_n` is high, so staged data does not reach `code_a`/`code_b`. While `ldac_n` is low, both latches copy their staging registers.
- R4: While `clr_n` is low, both latches are zero. This takes effect without waiting for a clock edge and overrides `ldac_n` low. The staging registers are not cleared.
- R5: With `fmt_twos` = 0 each code equals its latch. With `fmt_twos` = 1 each code equals its latch with bit 11 inverted. A cleared latch therefore gives 0x800.
- R6: Falling `sclk` edges after the 16th bit of a frame are ignored until `sync_n` rises and falls again.
- R7: If `sync_n` rises before 16 bits have arrived, the frame is abandoned and no register changes.
- R8: After reset both staging registers and both latches are zero.
- R9: `sclk` edges that occur while `sync_n` is high shift nothing and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| sync_n | input | 1 | Active-low frame strobe |
| ldac_n | input | 1 | Active-low level load of both latches |
| clr_n | input | 1 | Active-low asynchronous clear of both latches |
| fmt_twos | input | 1 | 1 selects two's-complement coding |
| code_a | output | 12 | Code sent to channel A's converter core |
| code_b | output | 12 | Code sent to channel B's converter core |

## Verification
The bench walks a one through all twelve payload positions on both channels, using a varied header each time. A wrong bit order would scramble the codes, and header leakage or an inverted routing bit would land the data on the wrong channel. Frames cut short, frames followed by extra clock edges, and clocking while the strobe is high each test whether the bit counter is guarded. A design that is not guarded here would change a staging register when it should not. Clear is checked one nanosecond after it falls, before any clock edge, and again with load held low. A clear synchronous to the clock, or one that load could override, would show a non-zero code at those points. Both coding modes are checked at zero, full scale and the two mid-scale codes, which exposes an inverted bit other than bit 11.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  parameter int DAC_W    = 12;
  parameter int HDR_W    = 3;
  parameter int SYNC_STG = 2;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;

  function automatic int frame_len(input int data_w, input int hdr_w);
    return hdr_w + 1 + data_w;
  endfunction
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dacif_frame.sv
module dacif_frame #(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 1),
  localparam int SH_W   = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdin_s,
  input  logic              sync_s,
  output logic              wr_stb,
  output logic              wr_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic             sclk_q, sync_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SH_W-1:0]  sh_q, word_q, shifted;
  logic             stb_q, stb_d;
  logic             sclk_fall, sync_fall, full, last, take;

  always_comb begin
    sclk_fall = sclk_q & ~sclk_s;
    sync_fall = sync_q & ~sync_s;
    full      = (cnt_q == CNT_W'(FRAME_W));
    last      = (cnt_q == CNT_W'(FRAME_W - 1));
    take      = sclk_fall & ~sync_s & ~full & ~sync_fall;
    shifted   = {sh_q[SH_W-2:0], sdin_s};
  end

  always_comb begin
    cnt_d = cnt_q;
    stb_d = 1'b0;
    if (sync_fall) begin
      cnt_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + CNT_W'(1);
      stb_d = last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      sync_q <= 1'b1;
      cnt_q  <= CNT_W'(FRAME_W);
      stb_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      sync_q <= sync_s;
      cnt_q  <= cnt_d;
      stb_q  <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (take) sh_q <= shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             word_q <= '0;
    else if (take && last)  word_q <= shifted;
  end

  assign wr_stb  = stb_q;
  assign wr_sel  = word_q[DATA_W];
  assign wr_data = word_q[DATA_W-1:0];
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
  import dacif_pkg::*;
#(
  parameter int    DATA_W = 12,
  parameter chan_e CH_ID  = CH_A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              wr_stb,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  input  logic              fmt_twos,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] lat_q,
  output logic [DATA_W-1:0] code
);
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic hit;

  always_comb hit = wr_stb & (wr_sel == logic'(CH_ID));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   in_q <= '0;
    else if (hit) in_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (!clr_n) lat_q <= '0;
    else if (load)   lat_q <= in_q;
  end

  always_comb code = fmt_twos ? (lat_q ^ MSB_MASK) : lat_q;
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
  import dacif_pkg::*;
#(
  parameter int DATA_W   = dacif_pkg::DAC_W,
  parameter int HDR_W    = dacif_pkg::HDR_W,
  parameter int SYNC_STG = dacif_pkg::SYNC_STG,
  localparam int FRAME_W = dacif_pkg::frame_len(DATA_W, HDR_W),
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              sync_n,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              fmt_twos,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b
);
  logic              rst_n_int;
  logic              sclk_s, sdin_s, sync_s, ldac_s, load;
  logic              wr_stb, wr_sel;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] in_q  [2];
  logic [DATA_W-1:0] lat_q [2];
  logic [DATA_W-1:0] code  [2];

  dacif_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_int));

  dacif_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sclk (
    .clk(clk), .rst_n(rst_n_int), .d(sclk), .q(sclk_s));
  dacif_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_sdin (
    .clk(clk), .rst_n(rst_n_int), .d(sdin), .q(sdin_s));
  dacif_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .d(sync_n), .q(sync_s));
  dacif_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_ldac (
    .clk(clk), .rst_n(rst_n_int), .d(ldac_n), .q(ldac_s));

  always_comb load = ~ldac_s;

  dacif_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n_int), .sclk_s(sclk_s), .sdin_s(sdin_s),
    .sync_s(sync_s), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_data(wr_data), .bit_cnt(bit_cnt));

  generate
    for (genvar c = 0; c < 2; c++) begin : g_ch
      dacif_chan #(.DATA_W(DATA_W), .CH_ID(chan_e'(c))) u_chan (
        .clk(clk), .rst_n(rst_n_int), .clr_n(clr_n), .wr_stb(wr_stb),
        .wr_sel(wr_sel), .wr_data(wr_data), .load(load),
        .fmt_twos(fmt_twos), .in_q(in_q[c]), .lat_q(lat_q[c]),
        .code(code[c]));
    end
  endgenerate

  assign code_a = code[0];
  assign code_b = code[1];
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              load,
  input logic              sync_s,
  input logic              wr_stb,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [DATA_W-1:0] lat_a,
  input logic [DATA_W-1:0] lat_b
);
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (lat_a == '0 && lat_b == '0));

  a_r3_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (load && clr_n) |=> (!clr_n || (lat_a == $past(in_a) && lat_b == $past(in_b))));

  a_r3_hold_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && clr_n) |=> (!clr_n || ($stable(lat_a) && $stable(lat_b))));

  a_r9_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sync_s |=> !wr_stb);

  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ($stable(in_a) || $stable(in_b)));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));
endmodule

bind dual_dac_serial_if dacif_checker #(
  .DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_int), .clr_n(clr_n), .load(load),
  .sync_s(sync_s), .wr_stb(wr_stb), .bit_cnt(bit_cnt),
  .in_a(in_q[0]), .in_b(in_q[1]), .lat_a(lat_q[0]), .lat_b(lat_q[1]));

// File: tb/sim_dual_dac_serial_if.sv
`timescale 1ns/1ps
module sim_dual_dac_serial_if;
  logic clk = 1'b0;
  logic rst_n, sclk, sdin, sync_n, ldac_n, clr_n, fmt_twos;
  logic [11:0] code_a, code_b;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [11:0] ina, inb, la, lb;

  always #5 clk = ~clk;

  dual_dac_serial_if u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .sync_n(sync_n),
    .ldac_n(ldac_n), .clr_n(clr_n), .fmt_twos(fmt_twos),
    .code_a(code_a), .code_b(code_b));

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mapc(input logic [11:0] l, input logic f);
    return f ? (l ^ 12'h800) : l;
  endfunction

  task automatic check_codes(input string req);
    check(req, code_a, mapc(la, fmt_twos));
    check(req, code_b, mapc(lb, fmt_twos));
  endtask

  task automatic send(input logic [15:0] w, input int nb, input int extra);
    @(negedge clk) sync_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < nb + extra; i++) begin
      sdin = (i < 16) ? w[15-i] : ~w[i % 16];
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(8);
      sclk = 1'b1;
    end
    wait_clk(8);
    sync_n = 1'b1;
    wait_clk(12);
    if (nb == 16) begin
      if (w[12]) inb = w[11:0];
      else       ina = w[11:0];
    end
  endtask

  task automatic idle_clocks(input logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      sdin = w[15-i];
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(8);
    end
    sclk = 1'b1;
    wait_clk(12);
  endtask

  task automatic load_pulse();
    @(negedge clk) ldac_n = 1'b0;
    wait_clk(2);
    ldac_n = 1'b1;
    wait_clk(6);
    la = ina;
    lb = inb;
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b1; sdin = 1'b0; sync_n = 1'b1;
    ldac_n = 1'b1; clr_n = 1'b1; fmt_twos = 1'b0;
    ina = '0; inb = '0; la = '0; lb = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    check_codes("R8 reset");
    load_pulse();
    check_codes("R8 staging zero after reset");

    // R1 R2 R3 walking-one sweep over every payload bit, both channels
    for (int i = 0; i < 12; i++) begin
      logic [11:0] a, b;
      logic [2:0]  h;
      a = 12'(1) << i;
      b = (~a) ^ 12'(i * 37);
      h = 3'(i);
      send({h, 1'b0, a}, 16, 0);
      send({~h, 1'b1, b}, 16, 0);
      check_codes("R3 held before load");
      load_pulse();
      check_codes("R1 R2 payload routed");
      fmt_twos = 1'b1; #1;
      check_codes("R5 twos mapping");
      fmt_twos = 1'b0; #1;
    end

    // R5 boundary codes
    for (int k = 0; k < 4; k++) begin
      logic [11:0] v;
      v = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : (k == 2) ? 12'h7FF : 12'h800;
      send({3'b101, 1'b0, v}, 16, 0);
      send({3'b010, 1'b1, ~v}, 16, 0);
      load_pulse();
      for (int f = 0; f < 2; f++) begin
        fmt_twos = f[0]; #1;
        check_codes("R5 boundary");
      end
      fmt_twos = 1'b0;
    end

    // R7 abandoned frame
    send({3'b000, 1'b0, 12'hABC}, 10, 0);
    send({3'b000, 1'b1, 12'h123}, 15, 0);
    load_pulse();
    check_codes("R7 abandoned frame");

    // R6 extra edges after the 16th bit
    send({3'b111, 1'b0, 12'h5A3}, 16, 5);
    send({3'b000, 1'b1, 12'hC3C}, 16, 3);
    load_pulse();
    check_codes("R6 extra edges");

    // R9 clocks with frame strobe high
    idle_clocks({3'b000, 1'b0, 12'h0F0});
    idle_clocks({3'b000, 1'b1, 12'h00F});
    load_pulse();
    check_codes("R9 idle clocks");

    // R4 asynchronous clear, priority over load, staging kept
    @(negedge clk) clr_n = 1'b0;
    #1;
    la = '0; lb = '0;
    check_codes("R4 async clear");
    fmt_twos = 1'b1; #1;
    check("R4 cleared twos mid-scale", code_a, 12'h800);
    check("R4 cleared twos mid-scale", code_b, 12'h800);
    @(negedge clk) ldac_n = 1'b0;
    wait_clk(5);
    check_codes("R4 clear beats load");
    clr_n = 1'b1;
    wait_clk(5);
    ldac_n = 1'b1;
    la = ina; lb = inb;
    wait_clk(4);
    check_codes("R4 staging survives clear");
    fmt_twos = 1'b0; #1;
    check_codes("R4 staging survives clear binary");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule